// File: doc/BRIEF.md
# Divider-Driven Programmable Timer

This block pairs a free-running divider with an 8-bit programmable counter. Each machine step, marked by a one-cycle `step` strobe, adds 4 to a 16-bit divider. The counter advances when the gated tap falls from 1 to 0. The gated tap is the control enable ANDed with one divider bit picked by the control select. The rule looks at that gated signal and not at the divider alone. So a write that clears the divider, or that changes the control setting, can cause one extra increment by producing such a fall.

When the counter wraps past its all-ones value, it takes the modulo value at once. A timer interrupt pulse follows one step later. A CPU-side register port gives access to the divider, counter, modulo and control registers. The same divider also drives two frame-sequencer pulses for an audio unit. In normal speed they come from divider bit 12; in double speed they come from bit 13.

The register port is plain: a write strobe with an address and data, and a combinational read chosen by a read address. The port takes one write in any cycle, so there is no back-pressure. Register writes in a cycle take priority over the divider advance of that same cycle.

Top module: `timer_unit`

## Requirements
- R1: After reset all registers read zero and no output pulses. Each cycle with `step` high adds 4 to the 16-bit divider. Register address 0 reads the divider's upper 8 bits.
- R2: Control bit 2 enables counting. Control bits [1:0] select the divider tap: 0 picks bit 9, 1 picks bit 3, 2 picks bit 5, 3 picks bit 7. The counter (address 1) increments once for each 1-to-0 change of the enable ANDed with the tap. While counting is disabled, it does not count.
- R3: When the counter wraps from 0xFF, it loads the modulo register (address 2) in the same cycle. The next step raises `timer_irq` for exactly one cycle, seen after that step's edge.
- R4: Any write to address 0 clears the whole divider. If the gated tap was 1 just before that write, the counter increments once.
- R5: A write to the control register (address 3) increments the counter once when the old setting was enabled with its tap bit at 1, and the new setting is either disabled or has its tap bit at 0. No other control write changes the counter.
- R6: `fs_tick` pulses for one cycle after divider bit 12 falls, or bit 13 when `double_speed` is high. `fs_tick_alt` pulses after that same bit rises. A fall caused by a divider write also counts.
- R7: A counter write made while an interrupt is pending after a wrap loads the written value and cancels that interrupt.
- R8: A modulo write made in the step interval right after the interrupt is also copied into the counter. At any other time, a modulo write leaves the counter unchanged.
- R9: A divider write in the same cycle as `step` leaves the divider at zero; the advance of that step is dropped.
- R10: Control reads return the 3 stored bits in [2:0] and zero above them. Writes to the control register keep only data bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step | input | 1 | Machine-step strobe, one cycle per step |
| double_speed | input | 1 | Selects divider bit 13 instead of bit 12 for the frame pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 divider, 1 counter, 2 modulo, 3 control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as the write address |
| rd_data | output | 8 | Combinational read data |
| timer_irq | output | 1 | One-cycle timer interrupt pulse |
| fs_tick | output | 1 | Frame-sequencer pulse on the falling edge of the selected bit |
| fs_tick_alt | output | 1 | Secondary pulse on the rising edge of the selected bit |

## Verification
Counter, divider and modulo values change at the clock edge that takes the step or the write. The bench drives each stimulus at a falling edge and reads the registers at the next falling edge, one edge later. `timer_irq` and both frame pulses are registered from the same edge that causes them and last exactly one cycle. They are therefore checked right after the causing step or write, and the interrupt is checked again one cycle later to confirm it has dropped. Every expected count comes from the divider value written out in steps (4 per step) against the tap period.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    RL_RUN  = 2'd0,
    RL_PEND = 2'd1,
    RL_DONE = 2'd2
  } reload_e;

  typedef enum logic [1:0] {
    A_DIV = 2'd0,
    A_CNT = 2'd1,
    A_MOD = 2'd2,
    A_CTL = 2'd3
  } addr_e;

  localparam int CTL_W  = 3;
  localparam int CTL_EN = 2;
  localparam int N_TAPS = 4;

  // divider bit watched for each select code
  function automatic int tap_index(input logic [1:0] sel);
    return (sel == 2'd0) ? 9 : (2 * int'(sel) + 1);
  endfunction
endpackage

// File: rtl/tmr_divider.sv
module tmr_divider #(
  parameter int DIV_W    = 16,
  parameter int STEP_INC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clr,
  output logic [DIV_W-1:0] div_q,
  output logic [DIV_W-1:0] div_d
);
  // a clear takes priority over the step advance
  always_comb begin
    if (clr)       div_d = '0;
    else if (step) div_d = div_q + DIV_W'(STEP_INC);
    else           div_d = div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/tmr_edges.sv
module tmr_edges
  import tmr_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int FS_NORM = 12,
  parameter int FS_FAST = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_q,
  input  logic [DIV_W-1:0] div_d,
  input  logic [CTL_W-1:0] ctl_q,
  input  logic [CTL_W-1:0] ctl_d,
  input  logic             double_speed,
  output logic             cnt_tick,
  output logic             fs_fall,
  output logic             fs_rise
);
  logic [N_TAPS-1:0] tap_now, tap_next;

  for (genvar s = 0; s < N_TAPS; s++) begin : g_tap
    localparam int TB = tap_index(2'(s));
    assign tap_now[s]  = div_q[TB];
    assign tap_next[s] = div_d[TB];
  end

  logic gate_now, gate_next;
  assign gate_now  = ctl_q[CTL_EN] & tap_now[ctl_q[1:0]];
  assign gate_next = ctl_d[CTL_EN] & tap_next[ctl_d[1:0]];
  // covers plain stepping, divider clears and control rewrites alike
  assign cnt_tick  = gate_now & ~gate_next;

  logic fs_now, fs_next;
  assign fs_now  = double_speed ? div_q[FS_FAST] : div_q[FS_NORM];
  assign fs_next = double_speed ? div_d[FS_FAST] : div_d[FS_NORM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_fall <= 1'b0;
      fs_rise <= 1'b0;
    end else begin
      fs_fall <= fs_now & ~fs_next;
      fs_rise <= ~fs_now & fs_next;
    end
  end

  logic unused_div_bits;
  assign unused_div_bits = ^{div_q, div_d};
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             tick,
  input  logic             wr_cnt,
  input  logic             wr_mod,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] mod_q,
  output reload_e          st_q,
  output logic             irq_q
);
  logic [CNT_W-1:0] cnt_d, mod_d;
  reload_e          st_d;
  logic             irq_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    mod_d = mod_q;
    irq_d = 1'b0;
    // reload sequence moves first within a step
    if (step) begin
      case (st_q)
        RL_PEND: begin irq_d = 1'b1; st_d = RL_DONE; end
        RL_DONE: st_d = RL_RUN;
        default: ;
      endcase
    end
    if (tick) begin
      if (cnt_q == '1) begin
        cnt_d = mod_q;
        st_d  = RL_PEND;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (wr_mod) begin
      mod_d = wr_data;
      if (st_q == RL_DONE) cnt_d = wr_data;
    end
    if (wr_cnt) begin
      cnt_d = wr_data;
      if (st_q == RL_PEND) begin
        st_d  = RL_RUN;
        irq_d = 1'b0;
      end else if (st_d == RL_PEND) begin
        st_d = RL_RUN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mod_q <= '0;
      st_q  <= RL_RUN;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mod_q <= mod_d;
      st_q  <= st_d;
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/timer_unit.sv
module timer_unit
  import tmr_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int CNT_W    = 8,
  parameter int STEP_INC = 4,
  parameter int FS_NORM  = 12,
  parameter int FS_FAST  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             double_speed,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             timer_irq,
  output logic             fs_tick,
  output logic             fs_tick_alt
);
  localparam int PAD_W = CNT_W - CTL_W;

  logic wr_div, wr_cnt, wr_mod, wr_ctl;
  assign wr_div = wr_en && (wr_addr == A_DIV);
  assign wr_cnt = wr_en && (wr_addr == A_CNT);
  assign wr_mod = wr_en && (wr_addr == A_MOD);
  assign wr_ctl = wr_en && (wr_addr == A_CTL);

  logic [CTL_W-1:0] ctl_q, ctl_d;
  assign ctl_d = wr_ctl ? wr_data[CTL_W-1:0] : ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  logic [DIV_W-1:0] div_q, div_d;
  logic             cnt_tick;
  logic [CNT_W-1:0] cnt_q, mod_q;
  reload_e          rl_state;

  tmr_divider #(.DIV_W(DIV_W), .STEP_INC(STEP_INC)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .clr   (wr_div),
    .div_q (div_q),
    .div_d (div_d)
  );

  tmr_edges #(.DIV_W(DIV_W), .FS_NORM(FS_NORM), .FS_FAST(FS_FAST)) u_edges (
    .clk          (clk),
    .rst_n        (rst_n),
    .div_q        (div_q),
    .div_d        (div_d),
    .ctl_q        (ctl_q),
    .ctl_d        (ctl_d),
    .double_speed (double_speed),
    .cnt_tick     (cnt_tick),
    .fs_fall      (fs_tick),
    .fs_rise      (fs_tick_alt)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .tick    (cnt_tick),
    .wr_cnt  (wr_cnt),
    .wr_mod  (wr_mod),
    .wr_data (wr_data),
    .cnt_q   (cnt_q),
    .mod_q   (mod_q),
    .st_q    (rl_state),
    .irq_q   (timer_irq)
  );

  always_comb begin
    case (rd_addr)
      A_DIV:   rd_data = div_q[DIV_W-1 -: CNT_W];
      A_CNT:   rd_data = cnt_q;
      A_MOD:   rd_data = mod_q;
      default: rd_data = {{PAD_W{1'b0}}, ctl_q};
    endcase
  end
endmodule

// File: rtl/timer_unit_chk.sv
module timer_unit_chk #(
  parameter int DIV_W    = 16,
  parameter int CNT_W    = 8,
  parameter int STEP_INC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step,
  input logic             wr_div,
  input logic             wr_cnt,
  input logic             wr_mod,
  input logic             wr_ctl,
  input logic [CNT_W-1:0] wr_data,
  input logic [DIV_W-1:0] div_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [2:0]       ctl_q,
  input logic [1:0]       st_q,
  input logic             timer_irq,
  input logic             fs_tick,
  input logic             fs_tick_alt
);
  assert_div_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
    step && !wr_div |=> div_q == $past(div_q) + DIV_W'(STEP_INC));

  assert_div_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_div |=> div_q == '0);

  assert_hold_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[2] && !wr_ctl && !wr_cnt && !wr_mod |=> $stable(cnt_q));

  assert_irq_after_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timer_irq |-> $past(st_q) == 2'd1);

  assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timer_irq |=> !timer_irq);

  assert_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt && st_q == 2'd1 |=> !timer_irq);

  assert_mod_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mod && !wr_cnt && st_q == 2'd2 |=> cnt_q == $past(wr_data));

  assert_fs_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fs_tick && fs_tick_alt));
endmodule

bind timer_unit timer_unit_chk #(
  .DIV_W(DIV_W), .CNT_W(CNT_W), .STEP_INC(STEP_INC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .step        (step),
  .wr_div      (wr_div),
  .wr_cnt      (wr_cnt),
  .wr_mod      (wr_mod),
  .wr_ctl      (wr_ctl),
  .wr_data     (wr_data),
  .div_q       (div_q),
  .cnt_q       (cnt_q),
  .ctl_q       (ctl_q),
  .st_q        (rl_state),
  .timer_irq   (timer_irq),
  .fs_tick     (fs_tick),
  .fs_tick_alt (fs_tick_alt)
);

// File: tb/tb_timer_unit.sv
`timescale 1ns/1ps
module tb_timer_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step = 1'b0;
  logic       double_speed = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic       timer_irq, fs_tick, fs_tick_alt;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  timer_unit dut (
    .clk(clk), .rst_n(rst_n), .step(step), .double_speed(double_speed),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .timer_irq(timer_irq), .fs_tick(fs_tick), .fs_tick_alt(fs_tick_alt)
  );

  localparam logic [1:0] AD = 2'd0, AC = 2'd1, AM = 2'd2, AT = 2'd3;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    rd_addr = a;
    #0.5;
    v = rd_data;
  endtask

  task automatic chk_reg(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) begin
      step = 1'b1;
      @(negedge clk);
    end
    step = 1'b0;
  endtask

  task automatic prep(input logic [7:0] ctl);
    wr(AD, 8'h00);
    wr(AT, ctl);
    wr(AC, 8'h00);
  endtask

  task automatic t_reset();
    chk_reg("R1 reset div", AD, 8'h00);
    chk_reg("R1 reset cnt", AC, 8'h00);
    chk_reg("R1 reset mod", AM, 8'h00);
    chk_reg("R1 reset ctl", AT, 8'h00);
    chk("R1 reset irq", {7'd0, timer_irq}, 8'h00);
    chk("R1 reset fs", {6'd0, fs_tick, fs_tick_alt}, 8'h00);
  endtask

  task automatic t_divider();
    wr(AD, 8'h00);
    steps(64);
    chk_reg("R1 div after 64 steps", AD, 8'h01);
    steps(192);
    chk_reg("R1 div after 256 steps", AD, 8'h04);
  endtask

  task automatic t_taps();
    prep(8'h05); steps(8);   chk_reg("R2 tap bit3", AC, 8'h02);
    prep(8'h06); steps(32);  chk_reg("R2 tap bit5", AC, 8'h02);
    prep(8'h07); steps(128); chk_reg("R2 tap bit7", AC, 8'h02);
    prep(8'h04); steps(512); chk_reg("R2 tap bit9", AC, 8'h02);
    prep(8'h01); steps(16);  chk_reg("R2 disabled", AC, 8'h00);
  endtask

  task automatic t_overflow();
    prep(8'h05); wr(AM, 8'hF0); wr(AC, 8'hFE);
    steps(7);
    chk_reg("R3 before wrap", AC, 8'hFF);
    steps(1);
    chk_reg("R3 reload value", AC, 8'hF0);
    chk("R3 no irq at wrap", {7'd0, timer_irq}, 8'h00);
    steps(1);
    chk("R3 irq next step", {7'd0, timer_irq}, 8'h01);
    @(negedge clk);
    chk("R3 irq one cycle", {7'd0, timer_irq}, 8'h00);
  endtask

  task automatic t_cancel();
    prep(8'h05); wr(AM, 8'hF0); wr(AC, 8'hFE);
    steps(8);
    wr(AC, 8'h33);
    steps(1);
    chk("R7 irq cancelled", {7'd0, timer_irq}, 8'h00);
    chk_reg("R7 written value kept", AC, 8'h33);
    steps(1);
    chk("R7 irq stays low", {7'd0, timer_irq}, 8'h00);
  endtask

  task automatic t_mod_copy();
    prep(8'h05); wr(AM, 8'hF0); wr(AC, 8'hFE);
    steps(9);
    wr(AM, 8'h55);
    chk_reg("R8 copied after irq", AC, 8'h55);
    steps(1);
    wr(AM, 8'h66);
    chk_reg("R8 not copied later", AC, 8'h55);
    chk_reg("R8 modulo stored", AM, 8'h66);
  endtask

  task automatic t_div_write();
    prep(8'h05); steps(1);
    wr(AD, 8'h00);
    chk_reg("R4 tap low no tick", AC, 8'h00);
    steps(2);
    wr(AD, 8'h9A);
    chk_reg("R4 tap high tick", AC, 8'h01);
    chk_reg("R4 divider cleared", AD, 8'h00);
  endtask

  task automatic t_ctl_glitch();
    prep(8'h05); steps(2);
    wr(AT, 8'h01); chk_reg("R5 disable tick", AC, 8'h01);
    wr(AT, 8'h05); chk_reg("R5 enable no tick", AC, 8'h01);
    wr(AT, 8'h06); chk_reg("R5 new tap low tick", AC, 8'h02);
    wr(AT, 8'h04); chk_reg("R5 old tap low", AC, 8'h02);
    prep(8'h04); steps(34);
    wr(AT, 8'h05); chk_reg("R5 old gate low", AC, 8'h00);
    wr(AT, 8'h07); chk_reg("R5 both taps high", AC, 8'h00);
    wr(AT, 8'h03); chk_reg("R5 disable from high", AC, 8'h01);
  endtask

  task automatic t_frame();
    double_speed = 1'b0;
    prep(8'h00);
    steps(1023);
    chk("R6 quiet before bit12", {6'd0, fs_tick, fs_tick_alt}, 8'h00);
    steps(1);
    chk("R6 rise bit12", {6'd0, fs_tick, fs_tick_alt}, 8'h01);
    steps(1024);
    chk("R6 fall bit12", {6'd0, fs_tick, fs_tick_alt}, 8'h02);
    double_speed = 1'b1;
    @(negedge clk);
    wr(AD, 8'h00);
    chk("R6 clear drops bit13", {6'd0, fs_tick, fs_tick_alt}, 8'h02);
    steps(1024);
    chk("R6 bit12 ignored fast", {6'd0, fs_tick, fs_tick_alt}, 8'h00);
    steps(1024);
    chk("R6 rise bit13", {6'd0, fs_tick, fs_tick_alt}, 8'h01);
    steps(2048);
    chk("R6 fall bit13", {6'd0, fs_tick, fs_tick_alt}, 8'h02);
    double_speed = 1'b0;
  endtask

  task automatic t_priority();
    prep(8'h05); steps(1);
    step = 1'b1; wr_en = 1'b1; wr_addr = AD; wr_data = 8'h00;
    @(negedge clk);
    step = 1'b0; wr_en = 1'b0;
    chk_reg("R9 no tick on clear", AC, 8'h00);
    steps(2);
    chk_reg("R9 step dropped", AC, 8'h00);
    steps(2);
    chk_reg("R9 tick from zero", AC, 8'h01);
  endtask

  task automatic t_regmap();
    wr(AT, 8'hFF); chk_reg("R10 ctl masked", AT, 8'h07);
    wr(AM, 8'hA5); chk_reg("R10 modulo map", AM, 8'hA5);
    wr(AC, 8'h3C); chk_reg("R10 counter map", AC, 8'h3C);
    wr(AT, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_divider();
    t_taps();
    t_overflow();
    t_cancel();
    t_mod_copy();
    t_div_write();
    t_ctl_glitch();
    t_frame();
    t_priority();
    t_regmap();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule